// File: doc/BRIEF.md
# Programmable Single-Pulse Delay Timer

This block takes a one-cycle pulse and reproduces it a run-time selectable number of clock cycles later. It holds no copy of the bit stream. A single down-counter is loaded with the requested delay when the pulse is accepted. The counter steps down once per clock, and the output pulse fires when the count runs out. Because there is only one counter, the block tracks one pulse at a time.

The delay value is sampled when a pulse is accepted, so the value on the input may change freely while a count runs. A pulse that arrives while a count is still running is dropped. Such a pulse sets a sticky overrun flag, which tells the surrounding logic that its spacing assumption was broken. The maximum delay is a parameter, 3454 by default. The delay input is exactly wide enough to hold that maximum.

Top module: `pdly_top`

## Requirements
- R1: A synchronous active-high reset drives `pulse_out` and `overrun` low and returns the block to idle. A reset during a count cancels the pending output pulse.
- R2: When `pulse_in` is high at clock edge E and the block is idle, `pulse_out` is high for exactly one cycle, starting just after edge E+N, where N is the delay value in effect.
- R3: The delay value is captured at the edge that accepts the pulse. Later changes to `delay_n` do not alter a count that is already running.
- R4: A `delay_n` of 0 is treated as a delay of 1.
- R5: `delay_n` is $clog2(MAX_DELAY+1) bits wide, which is 12 bits for the default MAX_DELAY of 3454. Values above MAX_DELAY are treated as MAX_DELAY.
- R6: A `pulse_in` sampled while a count runs, other than at its final edge, is ignored and produces no output pulse. It also sets `overrun` high from the following cycle.
- R7: Once set, `overrun` stays high until reset, including while later pulses are accepted and delayed normally.
- R8: A `pulse_in` sampled at the same edge on which the output fires is accepted as a new pulse and does not set `overrun`.
- R9: `pulse_out` is never high unless it ends a count started by an accepted pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Pulse to be delayed, sampled each rising edge |
| delay_n | input | $clog2(MAX_DELAY+1) (12) | Delay in clock cycles, captured on acceptance |
| pulse_out | output | 1 | Delayed one-cycle pulse, registered |
| overrun | output | 1 | Sticky flag: a pulse arrived while a count was running |

## Verification
Some properties are checked by assertions on every cycle:
- the counter steps down by one each cycle of a count;
- the loaded count stays within 1 to MAX_DELAY;
- the clamped delay stays in range;
- `pulse_out` fires only at the end of an active count;
- `overrun` never falls outside reset;
- both outputs are clear after reset.

The exact edge on which each output pulse appears can only be shown by the bench's scenarios, which compare against a scoreboard of expected cycles. The same holds for these behaviours:
- the capture of the delay value at acceptance;
- the treatment of 0 and of out-of-range values;
- the re-arm on the firing edge;
- the dropping of overlapping pulses;
- the cancellation by a mid-count reset.

// File: rtl/pdly_pkg.sv
package pdly_pkg;
  localparam int DEF_MAX_DELAY = 3454;

  function automatic int delay_width(input int max_delay);
    return $clog2(max_delay + 1);
  endfunction
endpackage

// File: rtl/pdly_norm.sv
module pdly_norm #(
  parameter int MAX_DELAY = pdly_pkg::DEF_MAX_DELAY,
  localparam int W = pdly_pkg::delay_width(MAX_DELAY)
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX_DELAY);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] capped;

  // Upper clamp is only needed when the field can encode more than MAX_DELAY
  generate
    if (((1 << W) - 1) == MAX_DELAY) begin : g_no_cap
      assign capped = raw_i;
    end else begin : g_cap
      assign capped = (raw_i > MAX_V) ? MAX_V : raw_i;
    end
  endgenerate

  assign val_o = (capped == '0) ? ONE_V : capped;

  always_comb begin
    if (!$isunknown(val_o)) begin
      AST_NORM_RANGE: assert (val_o >= ONE_V && val_o <= MAX_V); // R4
    end
  end
endmodule

// File: rtl/pdly_count.sv
module pdly_count #(
  parameter int MAX_DELAY = pdly_pkg::DEF_MAX_DELAY,
  localparam int W = pdly_pkg::delay_width(MAX_DELAY)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         active_o,
  output logic         term_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX_DELAY);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      active_o <= 1'b0;
    end else if (load_i) begin
      cnt      <= load_val_i;
      active_o <= 1'b1;
    end else if (active_o) begin
      if (cnt == ONE_V) begin
        cnt      <= '0;
        active_o <= 1'b0;
      end else begin
        cnt <= cnt - ONE_V;
      end
    end
  end

  assign term_o = active_o && (cnt == ONE_V);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (active_o && !term_o && !load_i) |=> (active_o && cnt == $past(cnt) - ONE_V)); // R2

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (cnt >= ONE_V && cnt <= MAX_V)); // R5
endmodule

// File: rtl/pdly_ctrl.sv
module pdly_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  input  logic active_i,
  input  logic term_i,
  output logic load_o,
  output logic pulse_o,
  output logic overrun_o
);
  logic collide;

  // accept when idle, or on the final edge of the running count
  assign load_o  = pulse_i && (!active_i || term_i);
  assign collide = pulse_i && active_i && !term_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      pulse_o <= term_i;
      if (collide) overrun_o <= 1'b1;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pulse_o && !overrun_o)); // R1

  AST_OUT_AFTER_COUNT: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(active_i)); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o); // R7
endmodule

// File: rtl/pdly_top.sv
module pdly_top #(
  parameter int MAX_DELAY = pdly_pkg::DEF_MAX_DELAY,
  localparam int W = pdly_pkg::delay_width(MAX_DELAY)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pulse_in,
  input  logic [W-1:0] delay_n,
  output logic         pulse_out,
  output logic         overrun
);
  logic [W-1:0] norm_val;
  logic         load;
  logic         active;
  logic         term;

  pdly_norm #(.MAX_DELAY(MAX_DELAY)) norm_i (
    .raw_i (delay_n),
    .val_o (norm_val)
  );

  pdly_count #(.MAX_DELAY(MAX_DELAY)) count_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (norm_val),
    .active_o   (active),
    .term_o     (term)
  );

  pdly_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .pulse_i   (pulse_in),
    .active_i  (active),
    .term_i    (term),
    .load_o    (load),
    .pulse_o   (pulse_out),
    .overrun_o (overrun)
  );
endmodule

// File: tb/pdly_top_tb_top.sv
module pdly_top_tb_top;
  localparam int MAXD = 3454;
  localparam int W    = $clog2(MAXD + 1);

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pulse_in = 1'b0;
  logic [W-1:0] delay_n = '0;
  logic         pulse_out;
  logic         overrun;

  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  int   seen = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  pdly_top #(.MAX_DELAY(MAXD)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .pulse_in  (pulse_in),
    .delay_n   (delay_n),
    .pulse_out (pulse_out),
    .overrun   (overrun)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compare output pulses against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (sb.size() > 0 && sb[0].cyc < cyc) begin
        exp_t m;
        m = sb.pop_front();
        check(1'b0, {m.tag, " missed pulse"}, cyc, m.cyc);
      end
      if (pulse_out) begin
        seen++;
        if (sb.size() == 0) begin
          check(1'b0, "R9 stray pulse", cyc, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.cyc == cyc, {e.tag, " pulse cycle"}, cyc, e.cyc);
        end
      end
    end
  end

  // driver: assumes it is called at a negedge; returns at the next one
  task automatic send(input int n, input int exp_delay, input bit expect_out, input string tag);
    exp_t e;
    delay_n  = W'(n);
    pulse_in = 1'b1;
    if (expect_out) begin
      e.cyc = cyc + 1 + exp_delay;
      e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    pulse_in = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sb.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(pulse_out == 1'b0, "R1 pulse_out after reset", pulse_out, 0);
    check(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int s0;
    @(negedge clk);
    do_reset();

    // R2 basic delays
    send(1, 1, 1'b1, "R2 n=1");      drain();
    send(2, 2, 1'b1, "R2 n=2");      drain();
    send(5, 5, 1'b1, "R2 n=5");      drain();
    send(100, 100, 1'b1, "R2 n=100"); drain();
    send(MAXD, MAXD, 1'b1, "R2 n=max"); drain();

    // R4 zero treated as one, R5 clamp above max
    send(0, 1, 1'b1, "R4 n=0");      drain();
    send(4000, MAXD, 1'b1, "R5 n=4000"); drain();

    // R3 delay changed during a count
    send(10, 10, 1'b1, "R3 captured n");
    delay_n = W'(3);
    drain();

    // R8 re-arm on the firing edge: first fires at E0+4, second sampled there
    send(4, 4, 1'b1, "R8 first");
    repeat (3) @(negedge clk);
    send(3, 3, 1'b1, "R8 second");
    drain();
    check(overrun == 1'b0, "R8 no overrun on firing edge", overrun, 0);

    // R6 overlap ignored, overrun set
    s0 = seen;
    send(20, 20, 1'b1, "R6 first");
    repeat (4) @(negedge clk);
    send(7, 0, 1'b0, "R6 ignored");
    check(overrun == 1'b1, "R6 overrun set", overrun, 1);
    drain();
    repeat (10) @(negedge clk);
    check(seen - s0 == 1, "R6 single output", seen - s0, 1);

    // R7 sticky while later pulses run normally
    send(3, 3, 1'b1, "R7 later pulse");
    drain();
    check(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
    do_reset();

    // R1 reset mid-count cancels the pulse
    send(50, 50, 1'b1, "R1 cancelled");
    repeat (10) @(negedge clk);
    s0 = seen;
    do_reset();
    repeat (60) @(negedge clk);
    check(seen == s0, "R1 no pulse after mid-count reset", seen - s0, 0);

    // R9 idle with no input: no output
    s0 = seen;
    repeat (30) @(negedge clk);
    check(seen == s0, "R9 quiet when idle", seen - s0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule